// File: doc/BRIEF.md
# Power-Good Strap Latch and Powerdown Sequencer

This block controls a single dual-use input pin for a clock generator. At power-up the pin acts as a power-good level. The first time it is seen high, the block captures six configuration straps once and decodes the CPU clock frequency from them. The block then starts the oscillator and, after a fixed VCO start delay, the PLLs. When the PLL reports lock, and after a short settling count, the outputs are opened. From that point the same pin is read as an active-low powerdown request.

A powerdown request counts only when the pin is sampled low at two consecutive CPU-complement rising edges. These edges reach the block as one-cycle strobes in the reference-clock domain. On entry, the differential gate closes at once. Each single-ended gate closes at the next falling edge of its own clock level. Only after every gate is closed is the PLL enable dropped, and one cycle later the oscillator enable. Releasing the pin restarts the oscillator and PLL sequence without taking the straps again.

A stabilisation timer bounds the wait for lock. If lock does not arrive in time, a sticky fault flag is set and the outputs stay gated. All timing is counted in reference clocks. A synchronous active-high reset returns the block to the wait-for-power-good state.

Top module: `pgood_seq`

## Requirements
- R1: The straps are taken once, in the cycle after the synchronised pin is first seen high, and `straps_valid` then rises. `strap_q` uses the same layout as `strap_in`: bit 5 and bit 4 are the two CPU select bits (high, low), bit 3 is a select bit with no effect on the CPU rate, bit 2 is the SATA/SRC choice, bit 1 is the debug-port choice and bit 0 is the 12/48 MHz choice. While `test_mode` is low, later strap changes and later pin transitions leave `strap_q` unchanged.
- R2: While `test_mode` is high and the straps are valid, `strap_q` and `cpu_mhz_x100` follow `strap_in` one cycle later.
- R3: `cpu_mhz_x100` gives the CPU rate in units of 10 kHz, decoded from bits 5:4 of the straps: 00 gives 10000, 01 gives 8333, 10 gives 13333 and 11 gives 16667. Bit 3 has no effect on it.
- R4: In the running state, powerdown starts only after the synchronised pin is sampled low at two consecutive `cpuc_rise` strobes. A single low sample followed by a high sample has no effect.
- R5: On powerdown entry, `diff_gate` falls first. Each `se_gate` bit falls only in the cycle after its `se_level` bit went from 1 to 0. `pll_en` falls only when all gates are low, and `osc_en` falls in the cycle after `pll_en` was already low.
- R6: When the synchronised pin is seen high in powerdown, `osc_en` rises and stays high with `pll_en` low for exactly VCO_DLY cycles. The lock-to-output timing of R8 then applies, and the straps are not taken again.
- R7: After reset, all enables stay low until the pin is seen high. `osc_en` then rises, and `pll_en` rises exactly VCO_DLY+1 cycles later. `pll_en` never rises unless `osc_en` was high in the previous cycle.
- R8: If `pll_lock` rises while the block waits for lock, `diff_gate` rises 3+ENA_DLY cycles later, and every `se_gate` bit rises one cycle after that.
- R9: If lock has not been seen STAB_LIMIT cycles after the VCO start, `lock_fault` rises, `pll_en` falls after exactly STAB_LIMIT-VCO_DLY high cycles, and all gates stay low. The fault stays set until reset. A lock observed in the last cycle before the limit still wins.
- R10: While reset is high, `osc_en`, `pll_en`, `diff_gate`, `se_gate`, `straps_valid`, `lock_fault` and `cpu_mhz_x100` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pg_pd_n | input | 1 | Dual-use pin: power-good, then active-low powerdown |
| strap_in | input | 6 | Strap inputs (layout in R1) |
| test_mode | input | 1 | Lets the straps be re-taken continuously |
| cpuc_rise | input | 1 | One-cycle strobe per CPU-complement rising edge |
| pll_lock | input | 1 | PLL lock indication (asynchronous) |
| se_level | input | N_SE | Current level of each single-ended output clock |
| osc_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL enable |
| diff_gate | output | 1 | Differential outputs running (0 forces low) |
| se_gate | output | N_SE | Per single-ended output run gate |
| strap_q | output | 6 | Latched straps |
| straps_valid | output | 1 | Straps have been taken |
| cpu_mhz_x100 | output | 16 | Decoded CPU rate, 10 kHz units |
| lock_fault | output | 1 | Lock did not arrive within the stabilisation limit |

## Verification
The close race is between PLL lock and the stabilisation timer, since both can be decided at the same clock edge. The bench counts reference cycles from the observed oscillator start and raises `pll_lock` so that the synchronised lock arrives either at the last edge before the limit or exactly at the limit. The first case must end with the outputs running and no fault. The second must end with `lock_fault` set and the gates closed. A second overlap comes from per-output parking: each single-ended gate must close on its own falling edge while the differential gate is already closed, and the bench checks every gate fall against the levels it drove.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

    localparam int STRAP_W = 6;
    localparam int FREQ_W  = 16;

    typedef struct packed {
        logic fsel_hi;
        logic fsel_lo;
        logic fsel_x;
        logic sata_sel;
        logic dbg_sel;
        logic usb12_sel;
    } strap_t;

    typedef enum logic [1:0] {
        CPU_100 = 2'b00,
        CPU_83  = 2'b01,
        CPU_133 = 2'b10,
        CPU_166 = 2'b11
    } cpu_sel_e;

    typedef enum logic [3:0] {
        ST_WAIT_PG,
        ST_SAMPLE,
        ST_VCO,
        ST_LOCK,
        ST_ENA,
        ST_RUN,
        ST_PARK,
        ST_PLL_OFF,
        ST_DOWN,
        ST_FAULT
    } seq_state_e;

    typedef struct packed {
        logic osc_en;
        logic pll_en;
        logic out_en;
        logic fault;
    } ctl_t;

    function automatic cpu_sel_e cpu_sel_of(input strap_t s);
        return cpu_sel_e'({s.fsel_hi, s.fsel_lo});
    endfunction

    function automatic logic [FREQ_W-1:0] cpu_rate_x100(input cpu_sel_e sel);
        logic [FREQ_W-1:0] r;
        unique case (sel)
            CPU_100: r = FREQ_W'(10000);
            CPU_83:  r = FREQ_W'(8333);
            CPU_133: r = FREQ_W'(13333);
            default: r = FREQ_W'(16667);
        endcase
        return r;
    endfunction

    function automatic ctl_t ctl_of(input seq_state_e st);
        ctl_t c;
        c = '0;
        unique case (st)
            ST_SAMPLE:  c.osc_en = 1'b1;
            ST_VCO:     c.osc_en = 1'b1;
            ST_LOCK:    begin c.osc_en = 1'b1; c.pll_en = 1'b1; end
            ST_ENA:     begin c.osc_en = 1'b1; c.pll_en = 1'b1; end
            ST_RUN:     begin c.osc_en = 1'b1; c.pll_en = 1'b1; c.out_en = 1'b1; end
            ST_PARK:    begin c.osc_en = 1'b1; c.pll_en = 1'b1; end
            ST_PLL_OFF: c.osc_en = 1'b1;
            ST_FAULT:   begin c.osc_en = 1'b1; c.fault = 1'b1; end
            default:    c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pgs_sync.sv
module pgs_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[g] <= '0;
            else     stage[g] <= stage[g-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/pgs_pd_filter.sv
module pgs_pd_filter (
    input  logic clk,
    input  logic rst,
    input  logic pin_s,
    input  logic cpuc_rise,
    output logic pd_req
);
    logic last_smp;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_smp <= 1'b1;
            pd_req   <= 1'b0;
        end else begin
            if (cpuc_rise) last_smp <= pin_s;
            if (pin_s)          pd_req <= 1'b0;
            else if (cpuc_rise) pd_req <= ~last_smp;
        end
    end
endmodule

// File: rtl/pgs_strap_latch.sv
module pgs_strap_latch
    import pgs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 take,
    input  logic                 test_mode,
    input  logic [STRAP_W-1:0]   strap_in,
    output strap_t               strap_q,
    output logic                 valid,
    output logic [FREQ_W-1:0]    cpu_x100
);
    strap_t s_in;
    logic   load;

    assign s_in = strap_t'(strap_in);
    assign load = take | (test_mode & valid);

    always_ff @(posedge clk) begin
        if (rst) begin
            strap_q  <= '0;
            valid    <= 1'b0;
            cpu_x100 <= '0;
        end else if (load) begin
            strap_q  <= s_in;
            valid    <= 1'b1;
            cpu_x100 <= cpu_rate_x100(cpu_sel_of(s_in));
        end
    end
endmodule

// File: rtl/pgs_gate_park.sv
module pgs_gate_park #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [N-1:0] level,
    output logic [N-1:0] gate
);
    logic [N-1:0] level_d;

    for (genvar i = 0; i < N; i++) begin : g_out
        always_ff @(posedge clk) begin
            if (rst) begin
                level_d[i] <= 1'b0;
                gate[i]    <= 1'b0;
            end else begin
                level_d[i] <= level[i];
                if (en)                            gate[i] <= 1'b1;
                else if (level_d[i] && !level[i])  gate[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pgs_seq_ctrl.sv
module pgs_seq_ctrl
    import pgs_pkg::*;
#(
    parameter int VCO_DLY    = 16,
    parameter int STAB_LIMIT = 96,
    parameter int ENA_DLY    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_s,
    input  logic pd_req,
    input  logic lock_s,
    input  logic gates_idle,
    output logic take_straps,
    output ctl_t ctl_q
);
    localparam int TW = $clog2(STAB_LIMIT + 1);
    localparam int EW = $clog2(ENA_DLY + 1);
    localparam logic [TW-1:0] VCO_END  = TW'(VCO_DLY - 1);
    localparam logic [TW-1:0] STAB_END = TW'(STAB_LIMIT - 1);
    localparam logic [EW-1:0] ENA_END  = EW'(ENA_DLY - 1);

    seq_state_e        state, nxt;
    logic [TW-1:0]     tmr;
    logic [EW-1:0]     ena_cnt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_WAIT_PG: if (pin_s) nxt = ST_SAMPLE;
            ST_SAMPLE:  nxt = ST_VCO;
            ST_VCO:     if (tmr == VCO_END) nxt = ST_LOCK;
            ST_LOCK: begin
                if (lock_s)               nxt = ST_ENA;
                else if (tmr == STAB_END) nxt = ST_FAULT;
            end
            ST_ENA:     if (ena_cnt == ENA_END) nxt = ST_RUN;
            ST_RUN:     if (pd_req) nxt = ST_PARK;
            ST_PARK:    if (gates_idle) nxt = ST_PLL_OFF;
            ST_PLL_OFF: nxt = ST_DOWN;
            ST_DOWN:    if (pin_s) nxt = ST_VCO;
            ST_FAULT:   nxt = ST_FAULT;
            default:    nxt = ST_WAIT_PG;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_WAIT_PG;
            tmr     <= '0;
            ena_cnt <= '0;
            ctl_q   <= '0;
        end else begin
            state <= nxt;
            ctl_q <= ctl_of(nxt);
            if (nxt == ST_VCO && state != ST_VCO) tmr <= '0;
            else if (state == ST_VCO || state == ST_LOCK) tmr <= tmr + 1'b1;
            if (state != ST_ENA) ena_cnt <= '0;
            else                 ena_cnt <= ena_cnt + 1'b1;
        end
    end

    assign take_straps = (state == ST_SAMPLE);
endmodule

// File: rtl/pgood_seq.sv
module pgood_seq
    import pgs_pkg::*;
#(
    parameter int N_SE       = 4,
    parameter int VCO_DLY    = 16,
    parameter int STAB_LIMIT = 96,
    parameter int ENA_DLY    = 4,
    parameter int SYNC_STG   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pg_pd_n,
    input  logic [STRAP_W-1:0]  strap_in,
    input  logic                test_mode,
    input  logic                cpuc_rise,
    input  logic                pll_lock,
    input  logic [N_SE-1:0]     se_level,
    output logic                osc_en,
    output logic                pll_en,
    output logic                diff_gate,
    output logic [N_SE-1:0]     se_gate,
    output logic [STRAP_W-1:0]  strap_q,
    output logic                straps_valid,
    output logic [FREQ_W-1:0]   cpu_mhz_x100,
    output logic                lock_fault
);
    logic   pin_s, lock_s, pd_req, take;
    logic [1:0] sync_q;
    ctl_t   ctl;
    strap_t straps;

    pgs_sync #(.W(2), .STAGES(SYNC_STG)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({pg_pd_n, pll_lock}),
        .q   (sync_q)
    );
    assign pin_s  = sync_q[1];
    assign lock_s = sync_q[0];

    pgs_pd_filter u_pdf (
        .clk       (clk),
        .rst       (rst),
        .pin_s     (pin_s),
        .cpuc_rise (cpuc_rise),
        .pd_req    (pd_req)
    );

    pgs_seq_ctrl #(
        .VCO_DLY    (VCO_DLY),
        .STAB_LIMIT (STAB_LIMIT),
        .ENA_DLY    (ENA_DLY)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .pin_s       (pin_s),
        .pd_req      (pd_req),
        .lock_s      (lock_s),
        .gates_idle  (~|se_gate),
        .take_straps (take),
        .ctl_q       (ctl)
    );

    pgs_strap_latch u_strap (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .test_mode (test_mode),
        .strap_in  (strap_in),
        .strap_q   (straps),
        .valid     (straps_valid),
        .cpu_x100  (cpu_mhz_x100)
    );

    pgs_gate_park #(.N(N_SE)) u_park (
        .clk   (clk),
        .rst   (rst),
        .en    (ctl.out_en),
        .level (se_level),
        .gate  (se_gate)
    );

    assign strap_q    = straps;
    assign osc_en     = ctl.osc_en;
    assign pll_en     = ctl.pll_en;
    assign diff_gate  = ctl.out_en;
    assign lock_fault = ctl.fault;
endmodule

// File: rtl/pgood_seq_chk.sv
module pgood_seq_chk #(
    parameter int N_SE = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            test_mode,
    input logic [N_SE-1:0] se_level,
    input logic            osc_en,
    input logic            pll_en,
    input logic            diff_gate,
    input logic [N_SE-1:0] se_gate,
    input logic [5:0]      strap_q,
    input logic            straps_valid,
    input logic            lock_fault
);
    assert_straps_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (straps_valid && $past(straps_valid) && !test_mode && !$past(test_mode))
        |-> $stable(strap_q));

    assert_pll_off_after_gates_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(pll_en) |-> (se_gate == '0 && !diff_gate));

    assert_osc_off_after_pll_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(osc_en) |-> !$past(pll_en));

    for (genvar i = 0; i < N_SE; i++) begin : g_fall
        assert_park_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
            $fell(se_gate[i]) |-> (!$past(se_level[i]) && $past(se_level[i], 2)));
    end

    assert_pll_after_osc_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(pll_en) |-> $past(osc_en));

    assert_gate_needs_clocks_R8: assert property (@(posedge clk) disable iff (rst)
        diff_gate |-> (pll_en && osc_en));

    assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        lock_fault |=> lock_fault);

    assert_fault_gated_R9: assert property (@(posedge clk) disable iff (rst)
        lock_fault |-> (!diff_gate && se_gate == '0 && !pll_en));
endmodule

bind pgood_seq pgood_seq_chk #(.N_SE(N_SE)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .test_mode    (test_mode),
    .se_level     (se_level),
    .osc_en       (osc_en),
    .pll_en       (pll_en),
    .diff_gate    (diff_gate),
    .se_gate      (se_gate),
    .strap_q      (strap_q),
    .straps_valid (straps_valid),
    .lock_fault   (lock_fault)
);

// File: tb/sim_pgood_seq.sv
module sim_pgood_seq;
    localparam int N    = 4;
    localparam int VCO  = 16;
    localparam int STAB = 96;
    localparam int ENA  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pin = 1'b0;
    logic [5:0] strap = '0;
    logic tmode = 1'b0;
    logic cpuc = 1'b0;
    logic lock = 1'b0;
    logic [N-1:0] lvl = '0;
    logic osc_en, pll_en, diff_gate, straps_valid, lock_fault;
    logic [N-1:0] se_gate;
    logic [5:0] strap_q;
    logic [15:0] cpu_x100;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pgood_seq #(.N_SE(N), .VCO_DLY(VCO), .STAB_LIMIT(STAB), .ENA_DLY(ENA)) u0 (
        .clk(clk), .rst(rst), .pg_pd_n(pin), .strap_in(strap), .test_mode(tmode),
        .cpuc_rise(cpuc), .pll_lock(lock), .se_level(lvl),
        .osc_en(osc_en), .pll_en(pll_en), .diff_gate(diff_gate), .se_gate(se_gate),
        .strap_q(strap_q), .straps_valid(straps_valid), .cpu_mhz_x100(cpu_x100),
        .lock_fault(lock_fault)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_cpu(input logic [5:0] s);
        case (s[5:4])
            2'b00:   return 10000;
            2'b01:   return 8333;
            2'b10:   return 13333;
            default: return 16667;
        endcase
    endfunction

    // Output clock levels and event monitor
    int cyc = 0;
    logic [N-1:0] lvl_prev = '0;
    logic [N-1:0] p_gate = '0;
    logic p_pll = 1'b0, p_osc = 1'b0, p_rst = 1'b1;
    always @(negedge clk) begin
        if (!rst && !p_rst) begin
            for (int i = 0; i < N; i++)
                if (p_gate[i] && !se_gate[i])
                    chk(!lvl[i] && lvl_prev[i], "R5", "gate fall not on level fall", i, i);
            if (p_pll && !pll_en)
                chk(se_gate == '0 && !diff_gate, "R5", "pll off with gates open",
                    int'(se_gate), 0);
            if (p_osc && !osc_en)
                chk(!p_pll, "R5", "osc off while pll was on", int'(p_pll), 0);
        end
        p_gate = se_gate; p_pll = pll_en; p_osc = osc_en; p_rst = rst;
        lvl_prev = lvl;
        cyc++;
        for (int i = 0; i < N; i++) lvl[i] = ((cyc / (i + 2)) % 2) != 0;
    end

    task automatic cyc_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_cpuc();
        cpuc = 1'b1;
        @(negedge clk);
        cpuc = 1'b0;
    endtask

    // Reset, then raise the pin; returns at the first negedge showing osc_en
    task automatic start_to_osc(input logic [5:0] s);
        rst = 1'b1; pin = 1'b0; lock = 1'b0; tmode = 1'b0; strap = s;
        cyc_n(3);
        chk(!osc_en && !pll_en && !diff_gate && se_gate == '0 && !straps_valid
            && !lock_fault && cpu_x100 == 0, "R10", "outputs in reset",
            int'({osc_en, pll_en, diff_gate, straps_valid, lock_fault}), 0);
        rst = 1'b0;
        cyc_n(5);
        chk(!osc_en && !pll_en, "R7", "enables before power-good",
            int'({osc_en, pll_en}), 0);
        pin = 1'b1;
        for (int t = 0; t < 20 && !osc_en; t++) @(negedge clk);
    endtask

    task automatic powerup(input logic [5:0] s);
        int n, m;
        start_to_osc(s);
        n = 1;
        for (int t = 0; t < 200; t++) begin
            @(negedge clk);
            if (pll_en) break;
            if (osc_en) n++;
        end
        chk(n == VCO + 1, "R7", "osc-only cycles at power-up", n, VCO + 1);
        chk(straps_valid && strap_q == s, "R1", "straps taken", int'(strap_q), int'(s));
        chk(int'(cpu_x100) == exp_cpu(s), "R3", "cpu rate", int'(cpu_x100), exp_cpu(s));
        lock = 1'b1;
        m = 0;
        for (int t = 0; t < 50 && !diff_gate; t++) begin @(negedge clk); m++; end
        chk(m == 3 + ENA, "R8", "lock to diff gate", m, 3 + ENA);
        chk(se_gate == '0, "R8", "se gates one cycle after diff", int'(se_gate), 0);
        @(negedge clk);
        chk(se_gate == '1, "R8", "se gates open", int'(se_gate), (1 << N) - 1);
    endtask

    // Watchdog
    initial begin
        #(20 * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [5:0] s, s2, held;
        int n, m;
        void'($urandom(32'd1234));

        // R1 R3: random straps, each CPU code forced
        for (int it = 0; it < 8; it++) begin
            s = 6'($urandom);
            s[5:4] = 2'(it % 4);
            powerup(s);
            s2 = s ^ 6'($urandom | 1);
            strap = s2;
            pin = 1'b0; cyc_n(3); pin = 1'b1; cyc_n(3);
            chk(strap_q == s, "R1", "straps ignored after latch", int'(strap_q), int'(s));
            chk(int'(cpu_x100) == exp_cpu(s), "R3", "rate held", int'(cpu_x100), exp_cpu(s));
        end

        // R3: bit 3 has no effect
        powerup(6'b011000);
        chk(cpu_x100 == 16'd8333, "R3", "select bit 3 ignored", int'(cpu_x100), 8333);

        // R2: test mode follows straps
        tmode = 1'b1; strap = 6'b110101; cyc_n(2);
        chk(strap_q == 6'b110101, "R2", "test mode strap follow", int'(strap_q), 53);
        chk(cpu_x100 == 16'd16667, "R2", "test mode rate", int'(cpu_x100), 16667);
        tmode = 1'b0; cyc_n(1); strap = 6'b000010; cyc_n(3);
        chk(strap_q == 6'b110101, "R1", "held after test mode", int'(strap_q), 53);
        held = strap_q;

        // R4: one low sample then high does nothing
        pin = 1'b0; cyc_n(3); pulse_cpuc();
        pin = 1'b1; cyc_n(3); pulse_cpuc(); cyc_n(4);
        chk(diff_gate == 1'b1, "R4", "single low sample ignored", int'(diff_gate), 1);
        // R4: two consecutive low samples
        pin = 1'b0; cyc_n(3); pulse_cpuc(); cyc_n(2); pulse_cpuc(); cyc_n(3);
        chk(diff_gate == 1'b0, "R4", "powerdown after two low samples", int'(diff_gate), 0);
        for (int t = 0; t < 100 && osc_en; t++) @(negedge clk);
        chk(!osc_en && !pll_en && se_gate == '0, "R5", "fully down",
            int'({osc_en, pll_en, se_gate}), 0);
        lock = 1'b0;
        cyc_n(5);

        // R6: wake
        pin = 1'b1; n = 0;
        for (int t = 0; t < 200; t++) begin
            @(negedge clk);
            if (pll_en) break;
            if (osc_en) n++;
        end
        chk(n == VCO, "R6", "osc-only cycles on wake", n, VCO);
        lock = 1'b1; m = 0;
        for (int t = 0; t < 50 && !diff_gate; t++) begin @(negedge clk); m++; end
        chk(m == 3 + ENA, "R6", "lock to diff gate on wake", m, 3 + ENA);
        chk(strap_q == held, "R6", "straps not retaken", int'(strap_q), int'(held));

        // R9: no lock at all
        start_to_osc(6'($urandom)); n = 0;
        for (int t = 0; t < 400 && !lock_fault; t++) begin
            @(negedge clk);
            if (pll_en) n++;
        end
        chk(lock_fault == 1'b1, "R9", "fault raised", int'(lock_fault), 1);
        chk(n == STAB - VCO, "R9", "pll-on cycles before fault", n, STAB - VCO);
        chk(!diff_gate && se_gate == '0 && !pll_en, "R9", "gated in fault",
            int'({diff_gate, se_gate, pll_en}), 0);
        lock = 1'b1; cyc_n(10);
        chk(lock_fault && !diff_gate, "R9", "fault sticky after late lock",
            int'({lock_fault, diff_gate}), 2);

        // R9: lock in the last deciding cycle wins
        start_to_osc(6'($urandom));
        cyc_n(STAB - 2); lock = 1'b1;
        for (int t = 0; t < 300 && !diff_gate && !lock_fault; t++) @(negedge clk);
        chk(!lock_fault && diff_gate, "R9", "last-cycle lock wins",
            int'({lock_fault, diff_gate}), 1);

        // R9: lock one cycle too late loses
        start_to_osc(6'($urandom));
        cyc_n(STAB - 1); lock = 1'b1;
        for (int t = 0; t < 300 && !diff_gate && !lock_fault; t++) @(negedge clk);
        chk(lock_fault && !diff_gate, "R9", "late lock faults",
            int'({lock_fault, diff_gate}), 2);

        // R10: reset from a faulted state
        rst = 1'b1; cyc_n(2);
        chk(!lock_fault && !osc_en && !straps_valid, "R10", "reset clears fault",
            int'({lock_fault, osc_en, straps_valid}), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule